// File: doc/BRIEF.md
# Burst-Resistant Packet Frame Encoder

The block turns a 128-bit message into the serial bit stream for an FSK transmitter. It sends a long alternating preamble and then a data packet, and it repeats this pair. The message is cut into sixteen bytes. Each byte leaves the block as a 14-bit word that carries its own position number and two even parity bits. A receiver can therefore rebuild every byte on its own, even when a burst interferer wipes out parts of a packet. The block advances one bit for each pulse of an external bit-rate tick. Its outputs feed a modulator, which is outside this block.

A start request captures the message together with two mode bits. In single mode the block sends exactly four preamble+packet pairs and then stops by itself. In continuous mode it repeats pairs until a stop request arrives, and it ends only on a packet boundary. An optional duty gate limits the transmit enable to the first half of every observation window of bit ticks. With the default window of 182 ticks, at about 18.2 kbit/s, the window is close to 10 ms.

Top module: `burst_frame_encoder`

## Requirements
- R1: After reset `ser_out`, `tx_en` and `done` are all 0, and they stay 0 until a start request.
- R2: Each pair begins with a preamble of 252 bits that alternate between 0 and 1, with 0 first. The data packet of 224 bits follows at once.
- R3: The packet sends words W0..W15 in that order, each MSB first. W0 takes `msg[127:120]` and Wk takes `msg[127-8k -: 8]`. A word is 8 data bits, MSB first, then the index k as 4 bits, MSB first, then a bit that makes the count of ones in the data bits even, then a bit that makes the count of ones in the index bits even.
- R4: In single mode (`cont_mode`=0) exactly four pairs (1904 bits) are sent, and then the block finishes.
- R5: In single mode a stop request has no effect: all four pairs are still sent.
- R6: In continuous mode (`cont_mode`=1) pairs repeat. A stop request ends the stream after the last bit of the data packet that is in progress, or of the packet whose last tick coincides with the stop. It never ends the stream inside a packet.
- R7: `done` is high for exactly one clock, in the cycle after the tick that sends the last bit. `tx_en` and `ser_out` are 0 in that same cycle.
- R8: With `duty_en`=1, `tx_en` is high for bit j (counted from 0 at start) exactly when j mod 182 < 91. With `duty_en`=0 it is high for every bit while busy.
- R9: The output bit changes only on a cycle where `bit_tick` is 1. Without ticks `ser_out` holds its value.
- R10: A start request while a stream is in progress is ignored: the stream continues with the message and modes that were captured first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| start | input | 1 | Start request; captures message and modes when idle |
| stop | input | 1 | Stop request (continuous mode only) |
| msg | input | 128 | Net message |
| cont_mode | input | 1 | 0 = four pairs, 1 = repeat until stop |
| duty_en | input | 1 | 1 = apply 50% transmit-enable gate |
| ser_out | output | 1 | Serial output bit |
| tx_en | output | 1 | Transmit enable |
| done | output | 1 | One-clock pulse at end of stream |

## Verification
A bit counter that slips by even one position shows up on `ser_out` at the next tick, as a broken 0/1 alternation or a word with the wrong index or parity. The bench compares every bit of every stream against a stream it builds itself. A wrong repetition or stop state shows only at the end of a stream, when `done` appears one packet too early or too late. The bench therefore counts the ticks exactly up to `done`. A duty counter that is out of phase shows within one window of 182 ticks as a shifted `tx_en` edge.

// File: rtl/burst_frame_encoder.sv
module burst_frame_encoder #(
  parameter int SYNC_LEN    = 252,
  parameter int REPEATS     = 4,
  parameter int DUTY_PERIOD = 182
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         start,
  input  logic         stop,
  input  logic [127:0] msg,
  input  logic         cont_mode,
  input  logic         duty_en,
  output logic         ser_out,
  output logic         tx_en,
  output logic         done
);
  localparam int SCW = $clog2(SYNC_LEN);
  localparam int RW  = $clog2(REPEATS) + 1;
  localparam int DCW = $clog2(DUTY_PERIOD);

  logic           busy_q, sync_q, cont_q, duty_q, stop_q, done_q;
  logic [SCW-1:0] scnt_q;
  logic [3:0]     word_q, pos_q;
  logic [RW-1:0]  rep_q;
  logic [DCW-1:0] dcnt_q;
  logic [127:0]   msg_q;

  logic [7:0]  byte_sel;
  logic [13:0] word_bits;
  logic        sync_last, data_last, finish;

  assign byte_sel  = msg_q[127 - 8*int'(word_q) -: 8];
  assign word_bits = {byte_sel, word_q, ^byte_sel, ^word_q};
  assign sync_last = sync_q && scnt_q == SCW'(SYNC_LEN - 1);
  assign data_last = !sync_q && word_q == 4'd15 && pos_q == 4'd13;
  assign finish    = busy_q && bit_tick && data_last &&
                     (cont_q ? (stop_q || stop) : rep_q == RW'(REPEATS - 1));

  assign ser_out = busy_q && (sync_q ? scnt_q[0] : word_bits[4'd13 - pos_q]);
  assign tx_en   = busy_q && (!duty_q || dcnt_q < DCW'(DUTY_PERIOD / 2));
  assign done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sync_q <= 1'b0;
      cont_q <= 1'b0;
      duty_q <= 1'b0;
      stop_q <= 1'b0;
      done_q <= 1'b0;
      scnt_q <= '0;
      word_q <= '0;
      pos_q  <= '0;
      rep_q  <= '0;
      dcnt_q <= '0;
      msg_q  <= '0;
    end else begin
      done_q <= finish;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          sync_q <= 1'b1;
          scnt_q <= '0;
          word_q <= '0;
          pos_q  <= '0;
          rep_q  <= '0;
          dcnt_q <= '0;
          stop_q <= 1'b0;
          msg_q  <= msg;
          cont_q <= cont_mode;
          duty_q <= duty_en;
        end
      end else begin
        if (cont_q && stop) stop_q <= 1'b1;
        if (bit_tick) begin
          dcnt_q <= (dcnt_q == DCW'(DUTY_PERIOD - 1)) ? '0 : dcnt_q + 1'b1;
          if (sync_q) begin
            if (sync_last) begin
              sync_q <= 1'b0;
              word_q <= '0;
              pos_q  <= '0;
            end else begin
              scnt_q <= scnt_q + 1'b1;
            end
          end else if (pos_q == 4'd13) begin
            pos_q <= '0;
            if (word_q == 4'd15) begin
              if (finish) begin
                busy_q <= 1'b0;
              end else begin
                sync_q <= 1'b1;
                scnt_q <= '0;
                rep_q  <= rep_q + 1'b1;
              end
            end else begin
              word_q <= word_q + 1'b1;
            end
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/burst_frame_encoder_chk.sv
module burst_frame_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic start,
  input logic ser_out,
  input logic tx_en,
  input logic done,
  input logic busy,
  input logic in_sync,
  input logic sync_end
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_txen_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!tx_en && !ser_out));

  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> $stable(ser_out));

  a_r2_sync_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_sync && !sync_end && bit_tick) |=> (ser_out != $past(ser_out)));

  a_r10_start_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !bit_tick) |=> busy);
endmodule

bind burst_frame_encoder burst_frame_encoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start),
  .ser_out(ser_out), .tx_en(tx_en), .done(done),
  .busy(busy_q), .in_sync(sync_q), .sync_end(sync_last)
);

// File: tb/burst_frame_encoder_tb.sv
module burst_frame_encoder_tb_top;
  localparam int PAIR = 476;
  localparam int DP   = 182;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, start = 1'b0, stop = 1'b0;
  logic cont_mode = 1'b0, duty_en = 1'b0;
  logic [127:0] msg = '0;
  logic ser_out, tx_en, done;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  burst_frame_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start), .stop(stop),
    .msg(msg), .cont_mode(cont_mode), .duty_en(duty_en),
    .ser_out(ser_out), .tx_en(tx_en), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_bit(input logic [127:0] m, input int j);
    int k = j % PAIR;
    int d, w, p;
    logic [7:0] b;
    logic [3:0] ix;
    logic [13:0] wd;
    if (k < 252) return k[0];
    d = k - 252; w = d / 14; p = d % 14;
    b = m[127 - 8*w -: 8];
    ix = 4'(w);
    wd = {b, ix, ^b, ^ix};
    return wd[13 - p];
  endfunction

  task automatic run_stream(input logic [127:0] m, input bit cont, input bit duty,
                            input int nbits, input int stop_at, input int restart_at,
                            input int hold_at, input string tag);
    int ser_bad = 0, en_bad = 0, first_j = -1, first_a = 0, first_e = 0;
    int early = 0;
    @(negedge clk);
    msg = m; cont_mode = cont; duty_en = duty; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int j = 0; j < nbits; j++) begin
      @(negedge clk);
      if (j == hold_at) begin
        repeat (3) @(negedge clk);
      end
      if (ser_out !== exp_bit(m, j)) begin
        ser_bad++;
        if (first_j < 0) begin first_j = j; first_a = ser_out; first_e = exp_bit(m, j); end
      end
      if (tx_en !== (duty ? ((j % DP) < DP/2) : 1'b1)) en_bad++;
      if (done) early++;
      bit_tick = 1'b1;
      if (j == stop_at) stop = 1'b1;
      if (j == restart_at) begin start = 1'b1; msg = ~m; cont_mode = ~cont; duty_en = ~duty; end
      @(posedge clk); #1;
      bit_tick = 1'b0; stop = 1'b0; start = 1'b0;
    end
    if (first_j >= 0) $display("  %s first bad bit at %0d", tag, first_j);
    chk(ser_bad == 0, {tag, " R2 R3 stream bits"}, first_a, first_e);
    chk(en_bad == 0, {tag, " R8 tx_en pattern"}, en_bad, 0);
    chk(early == 0, {tag, " R4 R6 no early done"}, early, 0);
    @(negedge clk);
    chk(done === 1'b1, {tag, " R7 done after last bit"}, done, 1);
    chk(tx_en === 1'b0 && ser_out === 1'b0, {tag, " R7 tx_en low with done"}, tx_en, 0);
    @(negedge clk);
    chk(done === 1'b0, {tag, " R7 done one clock"}, done, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(ser_out === 1'b0 && tx_en === 1'b0 && done === 1'b0, "R1 reset outputs", {ser_out, tx_en, done}, 0);
    rst_n = 1'b1;
    bit_tick = 1'b1;
    repeat (4) @(negedge clk);
    bit_tick = 1'b0;
    chk(ser_out === 1'b0 && tx_en === 1'b0 && done === 1'b0, "R1 idle without start", {ser_out, tx_en, done}, 0);
  endtask

  task automatic t_single_stop_ignored();
    logic [127:0] m;
    for (int i = 0; i < 16; i++) m[8*i +: 8] = 8'(i * 17 + 3);
    run_stream(m, 1'b0, 1'b0, 4 * PAIR, 700, -1, 10, "R4 R5 R9 single");
  endtask

  task automatic t_single_duty();
    run_stream({128{1'b1}}, 1'b0, 1'b1, 4 * PAIR, -1, -1, -1, "R8 duty single");
  endtask

  task automatic t_cont_stop_in_packet();
    run_stream({16{8'hA5}}, 1'b1, 1'b0, PAIR, 300, 100, -1, "R6 R10 cont stop in data");
  endtask

  task automatic t_cont_stop_second_pair();
    run_stream({8{16'h3C81}}, 1'b1, 1'b0, 2 * PAIR, PAIR + 5, -1, -1, "R6 cont stop in sync");
  endtask

  task automatic t_cont_stop_on_last();
    run_stream(128'h0123456789ABCDEF_FEDCBA9876543210, 1'b1, 1'b0, PAIR, PAIR - 1, -1, -1, "R6 cont stop on last bit");
  endtask

  task automatic t_single_restart();
    run_stream('0, 1'b0, 1'b0, 4 * PAIR, -1, 1000, -1, "R10 single restart ignored");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single_stop_ignored();
    t_single_duty();
    t_cont_stop_in_packet();
    t_cont_stop_second_pair();
    t_cont_stop_on_last();
    t_single_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule